// File: doc/BRIEF.md
# Serial and Parallel Output Channel Controller

This block is the digital control core of an eight-channel output switch. An SPI controller sets six of the channels through a serial command byte. Every channel also has its own parallel enable pin. Channels 0 to 5 turn on when either their serial bit or their pin asks for it. Channels 6 and 7 listen only to their pins. During each transfer the block returns the fault flags it captured when the transfer began. The fault sensing itself happens outside this block.

Frames longer than eight clocks pass through the shift register. The controller can therefore read back its own first byte to verify the command. Several devices can also be chained, with the serial output of one feeding the serial input of the next. A mode input keeps serial control disabled. While mode is low, the serially controlled channels stay off, for example during power-up.

All pin inputs that take part in the serial transfer are synchronized to a fast system clock before the edges are detected. The SPI clock must therefore run slower than the system clock. The block uses SPI mode 0: the serial clock idles low, and it is low when chip select changes.

Top module: `serial_chan_ctrl`

## Requirements
- R1: A falling edge on chip select starts a frame and captures the eight fault inputs into the shift register. The serial output then presents them MSB first: fault bit 7 is presented before the first clock, and the output moves to the next bit after each falling serial-clock edge.
- R2: The serial input is sampled on rising serial-clock edges, MSB first. When chip select rises, the low six bits of the byte held in the shift register become the serial commands, with bit i driving channel i for i from 0 to 5.
- R3: For each channel i from 0 to 5, the output equals the OR of serial command bit i and parallel pin i.
- R4: Outputs 6 and 7 equal parallel pins 6 and 7, whatever the serial data.
- R5: The serial output enable is low whenever no frame is active (chip select high). It is high throughout a frame.
- R6: In a 16-clock frame, the serial output returns the fault byte followed by the first byte received. The command is taken from the second byte received.
- R7: If chip select rises after a clock count that is not a multiple of eight, the command comes from the last eight bits shifted into the register. When the count is below eight, those bits include leftover fault bits.
- R8: Reset clears all serial commands, so every output then equals its parallel pin.
- R9: While mode is low, the serial commands are held at zero and frames do not load them. When mode goes high, the commands stay zero until the next completed frame.
- R10: Changes on the fault inputs during a frame do not affect the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the controller, idle low |
| cs_n_i | input | 1 | Active-low chip select that frames a transfer |
| si_i | input | 1 | Serial data in |
| mode_i | input | 1 | High enables serial control of channels 0 to 5 |
| par_i | input | 8 | Parallel enable pin for each channel |
| fault_i | input | 8 | Fault flag for each channel, captured at frame start |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o; low means the pin is released |
| out_o | output | 8 | Channel on/off controls |

## Verification
The bench runs 8-clock frames for all 256 command bytes. Each frame uses its own fault byte and a parallel pattern that changes with the command, so a wrong bit order or a wrong channel mapping shows up in both the returned status and the outputs. A sweep over all parallel patterns with a fixed command separates the OR on channels 0 to 5 from the pin-only channels 6 and 7. Frames of 16, 12 and 4 clocks show the pass-through and the rule that the last eight bits win, including leftover fault bits in short frames. Further runs toggle mode, change the fault inputs during a frame, and apply reset after a command has been set, to show the gating, the capture at frame start and the clearing of the commands.

// File: rtl/outctl_pkg.sv
package outctl_pkg;
    parameter int unsigned CHAN_N  = 8;
    parameter int unsigned SER_N   = 6;
    parameter int unsigned FRAME_W = 8;
    parameter int unsigned SYNC_N  = 2;
endpackage

// File: rtl/outctl_sync.sv
module outctl_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/outctl_shifter.sv
module outctl_shifter #(
    parameter int unsigned FRAME_W = outctl_pkg::FRAME_W,
    parameter int unsigned SER_N   = outctl_pkg::SER_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               sclk_i,
    input  logic               si_i,
    input  logic [FRAME_W-1:0] fault_i,
    output logic               so_o,
    output logic               so_oe_o,
    output logic               load_o,
    output logic [SER_N-1:0]   cmd_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               si_cap;
        logic               active;
        logic               cs_prev;
        logic               sclk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall;

    always_comb begin
        cs_fall   =  st_q.cs_prev & ~cs_n_i;
        cs_rise   = ~st_q.cs_prev &  cs_n_i;
        sclk_rise = ~st_q.sclk_prev &  sclk_i;
        sclk_fall =  st_q.sclk_prev & ~sclk_i;

        st_d           = st_q;
        st_d.cs_prev   = cs_n_i;
        st_d.sclk_prev = sclk_i;

        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.sr     = fault_i;
        end else if (cs_rise) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (sclk_rise) st_d.si_cap = si_i;
            if (sclk_fall) st_d.sr     = {st_q.sr[FRAME_W-2:0], st_q.si_cap};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr        <= '0;
            st_q.si_cap    <= 1'b0;
            st_q.active    <= 1'b0;
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_o    = st_q.active & st_q.sr[FRAME_W-1];
    assign so_oe_o = st_q.active;
    assign load_o  = cs_rise & st_q.active;
    assign cmd_o   = st_q.sr[SER_N-1:0];

    assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe_o);
    assert_oe_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> so_oe_o);
    assert_fault_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (st_q.sr == $past(fault_i)));
    assert_so_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !sclk_fall && !cs_rise && !cs_fall) |=> $stable(so_o));
endmodule

// File: rtl/outctl_drive.sv
module outctl_drive #(
    parameter int unsigned CHAN_N = outctl_pkg::CHAN_N,
    parameter int unsigned SER_N  = outctl_pkg::SER_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic [SER_N-1:0]  cmd_i,
    input  logic [CHAN_N-1:0] par_i,
    output logic [CHAN_N-1:0] out_o
);
    logic [SER_N-1:0] cmd_d, cmd_q;

    always_comb begin
        if (!mode_i)     cmd_d = '0;
        else if (load_i) cmd_d = cmd_i;
        else             cmd_d = cmd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    for (genvar i = 0; i < CHAN_N; i++) begin : g_chan
        if (i < SER_N) begin : g_ser
            assign out_o[i] = par_i[i] | cmd_q[i];
        end else begin : g_par
            assign out_o[i] = par_i[i];
        end
    end

    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> (cmd_q == '0));
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !load_i) |=> $stable(cmd_q));
    assert_cmd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && load_i) |=> (cmd_q == $past(cmd_i)));
endmodule

// File: rtl/serial_chan_ctrl.sv
module serial_chan_ctrl #(
    parameter int unsigned CHAN_N  = outctl_pkg::CHAN_N,
    parameter int unsigned SER_N   = outctl_pkg::SER_N,
    parameter int unsigned FRAME_W = outctl_pkg::FRAME_W,
    parameter int unsigned SYNC_N  = outctl_pkg::SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              si_i,
    input  logic              mode_i,
    input  logic [CHAN_N-1:0] par_i,
    input  logic [CHAN_N-1:0] fault_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [CHAN_N-1:0] out_o
);
    localparam int unsigned PIN_N = 4;
    localparam logic [PIN_N-1:0] PIN_RST = 4'b0010;

    logic [PIN_N-1:0] pin_raw, pin_sync;
    logic             load;
    logic [SER_N-1:0] cmd;

    assign pin_raw = {mode_i, si_i, cs_n_i, sclk_i};

    for (genvar p = 0; p < PIN_N; p++) begin : g_sync
        outctl_sync #(.STAGES(SYNC_N), .RST_VAL(PIN_RST[p])) i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_raw[p]),
            .level_o (pin_sync[p])
        );
    end

    outctl_shifter #(.FRAME_W(FRAME_W), .SER_N(SER_N)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (pin_sync[1]),
        .sclk_i  (pin_sync[0]),
        .si_i    (pin_sync[2]),
        .fault_i (fault_i[FRAME_W-1:0]),
        .so_o    (so_o),
        .so_oe_o (so_oe_o),
        .load_o  (load),
        .cmd_o   (cmd)
    );

    outctl_drive #(.CHAN_N(CHAN_N), .SER_N(SER_N)) i_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (pin_sync[3]),
        .load_i (load),
        .cmd_i  (cmd),
        .par_i  (par_i),
        .out_o  (out_o)
    );

    assert_pins67_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(par_i[CHAN_N-1:SER_N]) |-> $stable(out_o[CHAN_N-1:SER_N]));
endmodule

// File: tb/test_serial_chan_ctrl.sv
module test_serial_chan_ctrl;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, mode = 1'b0;
    logic [7:0] par = 8'h00, fault = 8'h00;
    logic so, so_oe;
    logic [7:0] outs;

    int n_run = 0, n_fail = 0;
    logic done = 1'b0;
    logic [31:0] rx;
    logic oe_mid;

    always #2 clk = ~clk;

    serial_chan_ctrl i_serial_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .si_i(si),
        .mode_i(mode), .par_i(par), .fault_i(fault),
        .so_o(so), .so_oe_o(so_oe), .out_o(outs)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_out(input logic [7:0] p, input logic [5:0] c);
        return {p[7:6], p[5:0] | c};
    endfunction

    // data holds the frame MSB-aligned at bit nbits-1
    task automatic frame(input int nbits, input logic [31:0] data,
                         input logic [7:0] flt, input logic [7:0] flt_mid);
        rx = '0;
        fault = flt;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = nbits - 1; b >= 0; b--) begin
            si = data[b];
            if (b == nbits - 2) fault = flt_mid;
            wait_clk(HALF);
            rx = {rx[30:0], so};
            if (b == nbits / 2) oe_mid = so_oe;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        par = 8'hC5;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R8 reset outputs", {24'd0, outs}, {24'd0, 8'hC5});
        check("R5 reset oe", {31'd0, so_oe}, 32'd0);
        mode = 1'b1;
        wait_clk(HALF);

        // R1 R2 R3 R4 R5: all command bytes, 8-bit frames
        for (int c = 0; c < 256; c++) begin
            logic [7:0] f, p;
            f = 8'(c * 37 + 11);
            p = (c % 4 == 0) ? 8'h00 : 8'(c * 91 + 3);
            par = p;
            oe_mid = 1'b0;
            frame(8, 32'(c), f, f);
            check("R1 status byte", rx, {24'd0, f});
            check("R5 oe in frame", {31'd0, oe_mid}, 32'd1);
            check("R5 oe idle", {31'd0, so_oe}, 32'd0);
            check("R2 R3 R4 outputs", {24'd0, outs}, {24'd0, expect_out(p, 6'(c))});
        end

        // R3 R4: parallel sweep with fixed command 0x2A
        par = 8'h00;
        frame(8, 32'h2A, 8'h00, 8'h00);
        for (int p = 0; p < 256; p++) begin
            par = 8'(p);
            wait_clk(1);
            check("R3 R4 par sweep", {24'd0, outs}, {24'd0, expect_out(8'(p), 6'h2A)});
        end
        par = 8'h00;

        // R6: 16-bit pass-through
        for (int k = 0; k < 6; k++) begin
            logic [15:0] d;
            logic [7:0] f;
            d = 16'(k * 16'h3B17 + 16'h1234);
            f = 8'(k * 53 + 7);
            frame(16, 32'(d), f, f);
            check("R6 status then echo", rx, {16'd0, f, d[15:8]});
            check("R6 second byte command", {24'd0, outs}, {24'd0, 2'b00, d[5:0]});
        end

        // R7: 12-bit and 4-bit frames
        frame(12, 32'hA5C, 8'h3C, 8'h3C);
        check("R7 12-bit echo", rx, {20'd0, 8'h3C, 4'hA});
        check("R7 12-bit command", {24'd0, outs}, {24'd0, 8'h1C});
        frame(4, 32'h9, 8'hE6, 8'hE6);
        check("R7 4-bit status", rx, {28'd0, 4'hE});
        check("R7 4-bit command", {24'd0, outs}, {24'd0, 8'h29});

        // R10: fault inputs changed mid-frame
        frame(8, 32'h00, 8'hB4, 8'h4B);
        check("R10 status latched", rx, {24'd0, 8'hB4});

        // R9: mode gating
        frame(8, 32'h3F, 8'h00, 8'h00);
        check("R9 preset command", {24'd0, outs}, {24'd0, 8'h3F});
        mode = 1'b0;
        wait_clk(HALF);
        check("R9 mode low clears", {24'd0, outs}, 32'd0);
        frame(8, 32'h15, 8'h00, 8'h00);
        check("R9 frame ignored", {24'd0, outs}, 32'd0);
        mode = 1'b1;
        wait_clk(HALF);
        check("R9 stays off after mode high", {24'd0, outs}, 32'd0);
        frame(8, 32'h15, 8'h00, 8'h00);
        check("R9 frame after mode high", {24'd0, outs}, {24'd0, 8'h15});

        // R8: reset clears a loaded command
        frame(8, 32'h3F, 8'h00, 8'h00);
        par = 8'h80;
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(HALF);
        check("R8 reset clears command", {24'd0, outs}, {24'd0, 8'h80});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule